// File: doc/BRIEF.md
# Split Receive Descriptor Writeback Formatter

This block serves a receive DMA engine that places each packet into two host buffers: a small buffer for the protocol headers and a larger buffer for the payload. On the fetch side it takes a 128-bit descriptor in read format and hands back the two buffer addresses. On the completion side it takes the byte counts that were stored in each buffer, together with the split mode and the header-split flags. From these it builds the fields of the writeback descriptor: the packet length, the header-info halfword and the status/error word.

The packet length in the writeback does not always equal the bytes written. It depends on the split mode and on two flags. The split flag (SPH) means the header was recognised and split off. The overflow flag (HBO) means the recognised header did not fit in the header buffer. Both sides of the block are registered. Each result appears one clock after its strobe and stays there until the next strobe.

Top module: `rx_split_wb_fmt`

## Requirements
- R1: One cycle after `rd_valid`, `rd_done` pulses high for one cycle. At the same time `hdr_buf_addr` shows descriptor bits [63:0] and `pay_buf_addr` shows bits [127:64], read as little-endian 64-bit words.
- R2: While `rst` is high, and in the cycle after it is released, every output is zero.
- R3: In split-always mode (`wb_mode`=1), `wb_pkt_len` equals `wb_pay_bytes` whatever the values of SPH and HBO.
- R4: In normal split mode (`wb_mode`=0), when SPH and HBO are both 0 or both 1, `wb_pkt_len` is `wb_hdr_bytes + wb_pay_bytes`. The sum saturates at 16'hFFFF.
- R5: In normal split mode with SPH=1 and HBO=0, `wb_pkt_len` equals `wb_pay_bytes`.
- R6: `wb_hdr_info` holds the low 10 bits of `wb_hdr_len` in bits [14:5] and SPH in bit 15. Bits [4:0] are 0, and bits of `wb_hdr_len` above bit 9 have no effect.
- R7: `wb_status` equals `wb_status_in`, with bit 21 also set when HBO=1.
- R8: The combination HBO=1 with SPH=0 is illegal. For it, `wb_bad_combo` is 1 in the `wb_done` cycle and `wb_pkt_len` equals `wb_pay_bytes`. For every other combination `wb_bad_combo` is 0.
- R9: One cycle after `wb_valid`, `wb_done` pulses for one cycle. Every writeback output keeps its value until the next `wb_valid`, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Descriptor present on `rd_desc` |
| rd_desc | input | 128 | Read-format descriptor |
| rd_done | output | 1 | Addresses updated |
| hdr_buf_addr | output | 64 | Header buffer address |
| pay_buf_addr | output | 64 | Payload buffer address |
| wb_valid | input | 1 | Writeback inputs present |
| wb_mode | input | 1 | 0 = normal split, 1 = split always |
| wb_hdr_bytes | input | 16 | Bytes stored in the header buffer |
| wb_pay_bytes | input | 16 | Bytes stored in the payload buffer |
| wb_hdr_len | input | 16 | Header length to report |
| wb_sph | input | 1 | Header was split |
| wb_hbo | input | 1 | Header buffer overflow |
| wb_status_in | input | 32 | Status/error word from other stages |
| wb_done | output | 1 | Writeback fields updated |
| wb_pkt_len | output | 16 | Packet length field |
| wb_hdr_info | output | 16 | Header-info halfword |
| wb_status | output | 32 | Status/error word with HBO merged in |
| wb_bad_combo | output | 1 | Illegal SPH/HBO combination seen |

## Verification
The results are held in registers that load only on a strobe, so any faulty internal state shows up in the cycle right after that strobe. A wrong length choice shows as a sum where a single count was expected, or the other way round. The bench therefore runs every SPH/HBO pair in both modes and checks the length one cycle after each strobe. A wrong hold enable shows as outputs that drift while the strobe is low. The bench checks for this by changing the inputs between strobes. Field position errors show in `wb_hdr_info` and `wb_status` as soon as a header length wider than 10 bits, or HBO set, is driven.

// File: rtl/rxsplit_pkg.sv
package rxsplit_pkg;

    localparam int DESC_W   = 128;
    localparam int ADDR_W   = 64;
    localparam int NUM_BUF  = 2;
    localparam int LEN_W    = 16;
    localparam int HINFO_W  = 16;
    localparam int HLEN_W   = 10;
    localparam int HLEN_LSB = 5;
    localparam int SPH_POS  = 15;
    localparam int STAT_W   = 32;
    localparam int HBO_POS  = 21;

    typedef enum logic {
        SPLIT_NORMAL = 1'b0,
        SPLIT_ALWAYS = 1'b1
    } split_mode_e;

    typedef struct packed {
        logic sph;
        logic hbo;
    } split_flags_t;

    typedef struct packed {
        logic [LEN_W-1:0]   pkt_len;
        logic [HINFO_W-1:0] hdr_info;
        logic [STAT_W-1:0]  status;
        logic               bad_combo;
    } wb_fields_t;

    // Sum of two byte counts, clamped to the largest length value.
    function automatic logic [LEN_W-1:0] sat_add(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        logic [LEN_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[LEN_W] ? {LEN_W{1'b1}} : s[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/rxs_desc_unpack.sv
module rxs_desc_unpack
    import rxsplit_pkg::*;
#(
    parameter int P_DESC_W = DESC_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_NBUF   = NUM_BUF
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [P_DESC_W-1:0]              in_desc,
    output logic                             out_valid,
    output logic [P_NBUF-1:0][P_ADDR_W-1:0]  out_addr
);
    localparam int USED_W = P_NBUF * P_ADDR_W;

    logic [P_NBUF-1:0][P_ADDR_W-1:0] slot;

    // Slot 0 (header buffer) sits in the low quadword, slot 1 above it.
    for (genvar g = 0; g < P_NBUF; g++) begin : g_slot
        assign slot[g] = in_desc[g*P_ADDR_W +: P_ADDR_W];
    end

    if (USED_W < P_DESC_W) begin : g_spare
        logic spare_unused;
        assign spare_unused = ^in_desc[P_DESC_W-1:USED_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= slot;
            end
        end
    end

endmodule

// File: rtl/rxs_len_select.sv
module rxs_len_select
    import rxsplit_pkg::*;
#(
    parameter int P_LEN_W = LEN_W
) (
    input  split_mode_e          mode,
    input  split_flags_t         flags,
    input  logic [P_LEN_W-1:0]   hdr_bytes,
    input  logic [P_LEN_W-1:0]   pay_bytes,
    output logic [P_LEN_W-1:0]   pkt_len,
    output logic                 bad_combo
);
    logic [P_LEN_W:0] full_sum;
    logic [P_LEN_W-1:0] sum_sat;
    logic use_sum;

    assign full_sum  = {1'b0, hdr_bytes} + {1'b0, pay_bytes};
    assign sum_sat   = full_sum[P_LEN_W] ? {P_LEN_W{1'b1}} : full_sum[P_LEN_W-1:0];
    assign bad_combo = flags.hbo && !flags.sph;

    always_comb begin
        use_sum = 1'b0;
        unique case (mode)
            SPLIT_ALWAYS: use_sum = 1'b0;
            SPLIT_NORMAL: use_sum = (flags.sph == flags.hbo);
            default:      use_sum = 1'b0;
        endcase
    end

    assign pkt_len = use_sum ? sum_sat : pay_bytes;

endmodule

// File: rtl/rxs_hinfo_pack.sv
module rxs_hinfo_pack
    import rxsplit_pkg::*;
#(
    parameter int P_HINFO_W = HINFO_W,
    parameter int P_HLEN_W  = HLEN_W,
    parameter int P_LSB     = HLEN_LSB,
    parameter int P_SPH     = SPH_POS,
    parameter int P_STAT_W  = STAT_W,
    parameter int P_HBO     = HBO_POS
) (
    input  logic [P_HINFO_W-1:0] hdr_len,
    input  split_flags_t         flags,
    input  logic [P_STAT_W-1:0]  status_in,
    output logic [P_HINFO_W-1:0] hdr_info,
    output logic [P_STAT_W-1:0]  status_out
);
    localparam logic [P_HINFO_W-1:0] FIELD_MASK =
        P_HINFO_W'(((1 << P_HLEN_W) - 1) << P_LSB);
    localparam logic [P_HINFO_W-1:0] SPH_BIT  = P_HINFO_W'(1) << P_SPH;
    localparam logic [P_STAT_W-1:0]  HBO_BIT  = P_STAT_W'(1) << P_HBO;

    logic [P_HINFO_W-1:0] shifted;

    assign shifted    = hdr_len << P_LSB;
    assign hdr_info   = (shifted & FIELD_MASK) | (flags.sph ? SPH_BIT : '0);
    assign status_out = status_in | (flags.hbo ? HBO_BIT : '0);

endmodule

// File: rtl/rx_split_wb_fmt.sv
module rx_split_wb_fmt
    import rxsplit_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_valid,
    input  logic [DESC_W-1:0]   rd_desc,
    output logic                rd_done,
    output logic [ADDR_W-1:0]   hdr_buf_addr,
    output logic [ADDR_W-1:0]   pay_buf_addr,
    input  logic                wb_valid,
    input  logic                wb_mode,
    input  logic [LEN_W-1:0]    wb_hdr_bytes,
    input  logic [LEN_W-1:0]    wb_pay_bytes,
    input  logic [HINFO_W-1:0]  wb_hdr_len,
    input  logic                wb_sph,
    input  logic                wb_hbo,
    input  logic [STAT_W-1:0]   wb_status_in,
    output logic                wb_done,
    output logic [LEN_W-1:0]    wb_pkt_len,
    output logic [HINFO_W-1:0]  wb_hdr_info,
    output logic [STAT_W-1:0]   wb_status,
    output logic                wb_bad_combo
);
    // ---------------- read side ----------------
    logic [NUM_BUF-1:0][ADDR_W-1:0] addr_q;

    rxs_desc_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rd_valid),
        .in_desc   (rd_desc),
        .out_valid (rd_done),
        .out_addr  (addr_q)
    );

    assign hdr_buf_addr = addr_q[0];
    assign pay_buf_addr = addr_q[1];

    // ---------------- writeback side ----------------
    split_mode_e  mode;
    split_flags_t flags;
    wb_fields_t   next_f;
    wb_fields_t   cur_f;
    logic         done_q;

    assign mode  = split_mode_e'(wb_mode);
    assign flags = '{sph: wb_sph, hbo: wb_hbo};

    rxs_len_select u_len (
        .mode      (mode),
        .flags     (flags),
        .hdr_bytes (wb_hdr_bytes),
        .pay_bytes (wb_pay_bytes),
        .pkt_len   (next_f.pkt_len),
        .bad_combo (next_f.bad_combo)
    );

    rxs_hinfo_pack u_hinfo (
        .hdr_len    (wb_hdr_len),
        .flags      (flags),
        .status_in  (wb_status_in),
        .hdr_info   (next_f.hdr_info),
        .status_out (next_f.status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            cur_f  <= '0;
        end else begin
            done_q <= wb_valid;
            if (wb_valid) begin
                cur_f <= next_f;
            end
        end
    end

    assign wb_done      = done_q;
    assign wb_pkt_len   = cur_f.pkt_len;
    assign wb_hdr_info  = cur_f.hdr_info;
    assign wb_status    = cur_f.status;
    assign wb_bad_combo = cur_f.bad_combo;

    // ---------------- assertions ----------------
    p_addr_split_r1: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> (rd_done && hdr_buf_addr == $past(rd_desc[63:0])
                      && pay_buf_addr == $past(rd_desc[127:64])));

    p_len_always_r3: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_mode) |=> (wb_pkt_len == $past(wb_pay_bytes)));

    p_len_split_r5: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_mode && wb_sph && !wb_hbo)
            |=> (wb_pkt_len == $past(wb_pay_bytes)));

    p_len_sum_r4: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_mode && (wb_sph == wb_hbo))
            |=> (wb_pkt_len == sat_add($past(wb_hdr_bytes), $past(wb_pay_bytes))));

    p_hdr_field_r6: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> (wb_hdr_info[14:5] == $past(wb_hdr_len[9:0])
                      && wb_hdr_info[15] == $past(wb_sph)
                      && wb_hdr_info[4:0] == 5'd0));

    p_hbo_status_r7: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> (wb_status[21] == ($past(wb_hbo) || $past(wb_status_in[21]))));

    p_bad_combo_r8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> (wb_bad_combo == ($past(wb_hbo) && !$past(wb_sph))));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wb_valid |=> (!wb_done && $stable(wb_pkt_len) && $stable(wb_hdr_info)
                       && $stable(wb_status) && $stable(wb_bad_combo)));

endmodule

// File: tb/sim_rx_split_wb_fmt.sv
module sim_rx_split_wb_fmt;

    logic         clk = 1'b0;
    logic         rst;
    logic         rd_valid;
    logic [127:0] rd_desc;
    logic         rd_done;
    logic [63:0]  hdr_buf_addr;
    logic [63:0]  pay_buf_addr;
    logic         wb_valid;
    logic         wb_mode;
    logic [15:0]  wb_hdr_bytes;
    logic [15:0]  wb_pay_bytes;
    logic [15:0]  wb_hdr_len;
    logic         wb_sph;
    logic         wb_hbo;
    logic [31:0]  wb_status_in;
    logic         wb_done;
    logic [15:0]  wb_pkt_len;
    logic [15:0]  wb_hdr_info;
    logic [31:0]  wb_status;
    logic         wb_bad_combo;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rx_split_wb_fmt u0 (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent model of the length rule.
    function automatic logic [15:0] model_len(input logic m, input logic s, input logic h,
                                             input logic [15:0] hb, input logic [15:0] pb);
        int sum;
        if (m || (s != h)) return pb;
        sum = int'(hb) + int'(pb);
        return (sum > 65535) ? 16'hFFFF : 16'(sum);
    endfunction

    // Drive one writeback at a negedge, check at the next negedge.
    task automatic do_wb(input string req, input logic m, input logic s, input logic h,
                         input logic [15:0] hb, input logic [15:0] pb,
                         input logic [15:0] hl, input logic [31:0] st);
        wb_valid = 1'b1; wb_mode = m; wb_sph = s; wb_hbo = h;
        wb_hdr_bytes = hb; wb_pay_bytes = pb; wb_hdr_len = hl; wb_status_in = st;
        @(negedge clk);
        wb_valid = 1'b0;
        chk({req, " done"}, 128'(wb_done), 128'd1);
        chk({req, " len"}, 128'(wb_pkt_len), 128'(model_len(m, s, h, hb, pb)));
        chk({req, " hinfo"}, 128'(wb_hdr_info),
            128'({s, hl[9:0], 5'd0}));
        chk({req, " status"}, 128'(wb_status), 128'(st | (h ? 32'h0020_0000 : 32'h0)));
        chk({req, " bad"}, 128'(wb_bad_combo), 128'(h & ~s));
    endtask

    task automatic t_reset;
        rst = 1'b1; rd_valid = 0; rd_desc = '0; wb_valid = 0; wb_mode = 0;
        wb_hdr_bytes = 0; wb_pay_bytes = 0; wb_hdr_len = 0; wb_sph = 0; wb_hbo = 0;
        wb_status_in = 0;
        repeat (3) @(negedge clk);
        chk("R2 in reset", {rd_done, hdr_buf_addr, pay_buf_addr}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 after release", {wb_done, wb_pkt_len, wb_hdr_info, wb_status, wb_bad_combo}, '0);
        chk("R2 rd after release", {rd_done, hdr_buf_addr, pay_buf_addr}, '0);
    endtask

    task automatic t_read;
        logic [63:0] a0 = 64'h0123_4567_89AB_CDE0;
        logic [63:0] a1 = 64'hFEDC_BA98_7654_3200;
        rd_valid = 1'b1; rd_desc = {a1, a0};
        @(negedge clk);
        rd_valid = 1'b0; rd_desc = '1;
        chk("R1 done", 128'(rd_done), 128'd1);
        chk("R1 hdr addr", 128'(hdr_buf_addr), 128'(a0));
        chk("R1 pay addr", 128'(pay_buf_addr), 128'(a1));
        @(negedge clk);
        chk("R1 pulse", 128'(rd_done), 128'd0);
        chk("R1 hold", 128'(hdr_buf_addr), 128'(a0));
        rd_valid = 1'b1; rd_desc = {64'h1, 64'hFFFF_0000_0000_0040};
        @(negedge clk);
        rd_valid = 1'b0;
        chk("R1 second hdr", 128'(hdr_buf_addr), 128'h0FFFF_0000_0000_0040);
        chk("R1 second pay", 128'(pay_buf_addr), 128'd1);
    endtask

    task automatic t_always;
        do_wb("R3 sph", 1'b1, 1'b1, 1'b0, 16'd40, 16'd1000, 16'd40, 32'h0);
        do_wb("R3 no split", 1'b1, 1'b0, 1'b0, 16'd128, 16'd0, 16'd128, 32'h1);
        do_wb("R3 overflow", 1'b1, 1'b1, 1'b1, 16'd256, 16'd700, 16'd300, 32'h0);
    endtask

    task automatic t_normal_sum;
        do_wb("R4 none", 1'b0, 1'b0, 1'b0, 16'd64, 16'd200, 16'd64, 32'h0);
        do_wb("R4 both", 1'b0, 1'b1, 1'b1, 16'd256, 16'd1200, 16'd400, 32'h0);
        do_wb("R4 saturate", 1'b0, 1'b0, 1'b0, 16'hFFF0, 16'h0020, 16'd0, 32'h0);
        chk("R4 saturate value", 128'(wb_pkt_len), 128'hFFFF);
    endtask

    task automatic t_normal_split;
        do_wb("R5", 1'b0, 1'b1, 1'b0, 16'd54, 16'd1446, 16'd54, 32'h0);
        chk("R5 value", 128'(wb_pkt_len), 128'd1446);
    endtask

    task automatic t_hinfo;
        do_wb("R6 wide", 1'b0, 1'b1, 1'b0, 16'd10, 16'd10, 16'hFFFF, 32'h0);
        chk("R6 wide value", 128'(wb_hdr_info), 128'hFFE0);
        do_wb("R6 nosph", 1'b0, 1'b0, 1'b0, 16'd54, 16'd0, 16'd54, 32'h0);
        chk("R6 nosph value", 128'(wb_hdr_info), 128'h06C0);
    endtask

    task automatic t_status;
        do_wb("R7 hbo", 1'b0, 1'b1, 1'b1, 16'd1, 16'd1, 16'd1, 32'h0000_0003);
        chk("R7 value", 128'(wb_status), 128'h0020_0003);
        do_wb("R7 pass", 1'b0, 1'b1, 1'b0, 16'd1, 16'd1, 16'd1, 32'h8000_0001);
        chk("R7 pass value", 128'(wb_status), 128'h8000_0001);
    endtask

    task automatic t_bad;
        do_wb("R8 illegal", 1'b0, 1'b0, 1'b1, 16'd90, 16'd500, 16'd90, 32'h0);
        chk("R8 flag", 128'(wb_bad_combo), 128'd1);
        chk("R8 len", 128'(wb_pkt_len), 128'd500);
        do_wb("R8 clear", 1'b0, 1'b1, 1'b1, 16'd90, 16'd500, 16'd90, 32'h0);
        chk("R8 cleared", 128'(wb_bad_combo), 128'd0);
    endtask

    task automatic t_hold;
        do_wb("R9 base", 1'b0, 1'b1, 1'b0, 16'd20, 16'd333, 16'd20, 32'h4);
        wb_mode = 1'b0; wb_sph = 1'b0; wb_hbo = 1'b1; wb_hdr_bytes = 16'd7;
        wb_pay_bytes = 16'd9; wb_hdr_len = 16'd3; wb_status_in = 32'hFFFF_FFFF;
        @(negedge clk);
        chk("R9 pulse", 128'(wb_done), 128'd0);
        @(negedge clk);
        chk("R9 held", {wb_pkt_len, wb_hdr_info, wb_status, wb_bad_combo},
            {16'd333, 16'h8280, 32'h4, 1'b0});
    endtask

    initial begin
        t_reset();
        t_read();
        t_always();
        t_normal_sum();
        t_normal_split();
        t_hinfo();
        t_status();
        t_bad();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule